// File: doc/BRIEF.md
# System Controller Register Bank

This block is the register front end of a small system controller. It sits on a word-oriented register bus and holds sixteen 32-bit registers. Three of them are GPIO registers: a strapping input, a driven output, and an interrupt-enable mask. It also holds a configuration-port command register, a capability word and a system identifier. Two windows of three words each belong to two timers. The timer counting logic is outside this block. The bank decodes those windows and forwards the access to the matching timer, and it places that timer's read data on its own read response. Writes to two registers have side effects. A write to the identifier register asks the system to reset. A shutdown command written to the configuration port asks the system to power down.

The bus side takes one access per cycle and never stalls, so it has no back-pressure. A request is taken on every clock edge where `bus_valid` is high. A read returns its data on `rd_data` with `rd_valid` high for exactly one cycle, on the cycle after the request. Writes produce no response.

Top module: `sysctl_bank`

## Requirements
- R1: The register index is the byte address shifted right by two. Byte-address bits [1:0] never change the result of an access.
- R2: After reset the registers read as follows. Index 0 (GPIO input) reads the strapping value 0x00000001. Index 13 (configuration port) reads 0x00000001, the ready flag in bit 0. Index 14 (capabilities) reads 0x00000000. Index 15 (identifier) reads 0x10014D31. Index 1 (GPIO output) and index 2 (interrupt enable) read zero, and `gpio_out` and `gpio_irq_en` are zero.
- R3: A read taken at a clock edge puts `rd_valid` high for exactly the next cycle, with `rd_data` valid in that cycle. A write never raises `rd_valid`.
- R4: A write to index 1 or index 2 stores the full 32-bit word. It appears on `gpio_out` or `gpio_irq_en` one cycle after the write, and a later read of that index returns it. No other access changes these two registers.
- R5: Index 0 and index 14 are read-only. Writes to them leave their read values unchanged.
- R6: A write of any value to index 15 raises `reset_req` for exactly one cycle, on the cycle after the write. The identifier still reads 0x10014D31 afterwards.
- R7: A write to index 13 whose bits [15:0] equal 0x000E raises `shutdown_req` for exactly one cycle, on the cycle after the write. Any other value raises nothing. Index 13 keeps reading 0x00000001.
- R8: Timer k (k = 0, 1) owns indices 4k+4, 4k+5 and 4k+6 (control, compare, counter). During an access to one of these indices, `tmr_sel` has only bit k set and `tmr_sub` is 0, 1 or 2 for control, compare or counter. `tmr_write` equals `bus_write` and `tmr_wdata` equals `bus_wdata`. A read returns the `tmr_rdata` slice [32k+31:32k] as it stood in the request cycle. At all other times `tmr_sel` is zero.
- R9: Indices 3, 7, 11 and 12, and every index of 16 or more, read zero. Writes to them change no output and raise no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Access request, taken every cycle it is high |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (8) | Byte address |
| bus_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle per read |
| rd_data | output | 32 | Read data |
| gpio_out | output | 32 | GPIO output register |
| gpio_irq_en | output | 32 | GPIO interrupt-enable mask |
| tmr_sel | output | NUM_TIMERS (2) | One-hot select of the addressed timer |
| tmr_write | output | 1 | Write qualifier for the selected timer |
| tmr_sub | output | 2 | Register within timer: 0 control, 1 compare, 2 counter |
| tmr_wdata | output | 32 | Write data to the selected timer |
| tmr_rdata | input | 32*NUM_TIMERS | Read data from the timers, timer k in bits [32k+31:32k] |
| reset_req | output | 1 | One-cycle system reset request |
| shutdown_req | output | 1 | One-cycle shutdown request |

## Verification
The assertions check four things on every cycle. Each request pulse must follow the write that causes it. `rd_valid` must follow only a read. The timer select must stay one-hot or clear, and it must be one-hot whenever a timer write is forwarded. The GPIO registers must hold unless their own index was written. The bench scenarios cover what no single-cycle property can show. They sweep every index through reads after reset and through writes with distinct patterns, then read everything back, which shows the reset values, the read-only and reserved holes, and the timer read selection. They also write several command values to the configuration port to show that only 0x000E in the low half-word requests a shutdown.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  localparam int WORD_W = 32;

  // Register indices (word address)
  localparam int IX_GPIO_IN  = 0;
  localparam int IX_GPIO_OUT = 1;
  localparam int IX_IRQ_EN   = 2;
  localparam int IX_CFG_PORT = 13;
  localparam int IX_CAPS     = 14;
  localparam int IX_SYS_ID   = 15;
  localparam int TMR_BASE    = 4;   // timer k starts at TMR_BASE*(k+1)
  localparam int TMR_WORDS   = 3;

  localparam logic [WORD_W-1:0] CFG_READY   = 32'h0000_0001;
  localparam logic [15:0]       CMD_SHUTDOWN = 16'h000E;

  typedef struct packed {
    logic gpio_out;
    logic irq_en;
    logic cfg_port;
    logic sys_id;
  } wr_hit_t;
endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
  import sysctl_pkg::*;
#(
  parameter int IDX_W      = 6,
  parameter int NUM_TIMERS = 2
) (
  input  logic [IDX_W-1:0]      idx,
  input  logic                  valid,
  input  logic                  write,
  output wr_hit_t               hit,
  output logic [NUM_TIMERS-1:0] tsel,
  output logic [1:0]            tsub
);
  logic wr;
  assign wr = valid && write;

  always_comb begin
    hit.gpio_out = wr && (idx == IDX_W'(IX_GPIO_OUT));
    hit.irq_en   = wr && (idx == IDX_W'(IX_IRQ_EN));
    hit.cfg_port = wr && (idx == IDX_W'(IX_CFG_PORT));
    hit.sys_id   = wr && (idx == IDX_W'(IX_SYS_ID));
  end

  for (genvar k = 0; k < NUM_TIMERS; k++) begin : g_tsel
    localparam int BASE = TMR_BASE * (k + 1);
    assign tsel[k] = valid && (idx >= IDX_W'(BASE)) &&
                     (idx < IDX_W'(BASE + TMR_WORDS));
  end

  // Timer windows are 4-word aligned, so the sub-index is the low index bits
  assign tsub = idx[1:0];
endmodule

// File: rtl/sysctl_gpio_regs.sv
module sysctl_gpio_regs
  import sysctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  wr_hit_t           hit,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] gpio_out,
  output logic [WORD_W-1:0] irq_en
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gpio_out <= '0;
      irq_en   <= '0;
    end else begin
      if (hit.gpio_out) gpio_out <= wdata;
      if (hit.irq_en)   irq_en   <= wdata;
    end
  end
endmodule

// File: rtl/sysctl_strobe.sv
module sysctl_strobe
  import sysctl_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  wr_hit_t     hit,
  input  logic [15:0] cmd,
  output logic        reset_req,
  output logic        shutdown_req
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reset_req    <= 1'b0;
      shutdown_req <= 1'b0;
    end else begin
      reset_req    <= hit.sys_id;
      shutdown_req <= hit.cfg_port && (cmd == CMD_SHUTDOWN);
    end
  end
endmodule

// File: rtl/sysctl_rdmux.sv
module sysctl_rdmux
  import sysctl_pkg::*;
#(
  parameter int                IDX_W      = 6,
  parameter int                NUM_TIMERS = 2,
  parameter logic [WORD_W-1:0] STRAP      = 32'h0000_0001,
  parameter logic [WORD_W-1:0] CAPS       = 32'h0000_0000,
  parameter logic [WORD_W-1:0] SYS_ID     = 32'h1001_4D31
) (
  input  logic [IDX_W-1:0]             idx,
  input  logic [NUM_TIMERS-1:0]        tsel,
  input  logic [WORD_W-1:0]            gpio_out,
  input  logic [WORD_W-1:0]            irq_en,
  input  logic [WORD_W*NUM_TIMERS-1:0] tmr_rdata,
  output logic [WORD_W-1:0]            rdata
);
  logic [WORD_W-1:0] local_rd;
  logic [WORD_W-1:0] tmr_rd;

  always_comb begin
    local_rd = '0;
    if      (idx == IDX_W'(IX_GPIO_IN))  local_rd = STRAP;
    else if (idx == IDX_W'(IX_GPIO_OUT)) local_rd = gpio_out;
    else if (idx == IDX_W'(IX_IRQ_EN))   local_rd = irq_en;
    else if (idx == IDX_W'(IX_CFG_PORT)) local_rd = CFG_READY;
    else if (idx == IDX_W'(IX_CAPS))     local_rd = CAPS;
    else if (idx == IDX_W'(IX_SYS_ID))   local_rd = SYS_ID;
  end

  always_comb begin
    tmr_rd = '0;
    for (int k = 0; k < NUM_TIMERS; k++)
      if (tsel[k]) tmr_rd = tmr_rd | tmr_rdata[k*WORD_W +: WORD_W];
  end

  assign rdata = local_rd | tmr_rd;
endmodule

// File: rtl/sysctl_bank.sv
module sysctl_bank
  import sysctl_pkg::*;
#(
  parameter int                ADDR_W     = 8,
  parameter int                NUM_TIMERS = 2,
  parameter logic [WORD_W-1:0] STRAP      = 32'h0000_0001,
  parameter logic [WORD_W-1:0] CAPS       = 32'h0000_0000,
  parameter logic [WORD_W-1:0] SYS_ID     = 32'h1001_4D31
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         bus_valid,
  input  logic                         bus_write,
  input  logic [ADDR_W-1:0]            bus_addr,
  input  logic [WORD_W-1:0]            bus_wdata,
  output logic                         rd_valid,
  output logic [WORD_W-1:0]            rd_data,
  output logic [WORD_W-1:0]            gpio_out,
  output logic [WORD_W-1:0]            gpio_irq_en,
  output logic [NUM_TIMERS-1:0]        tmr_sel,
  output logic                         tmr_write,
  output logic [1:0]                   tmr_sub,
  output logic [WORD_W-1:0]            tmr_wdata,
  input  logic [WORD_W*NUM_TIMERS-1:0] tmr_rdata,
  output logic                         reset_req,
  output logic                         shutdown_req
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0]  idx;
  logic [1:0]        unused_byte_lane;
  wr_hit_t           hit;
  logic [WORD_W-1:0] rd_mux;

  assign idx              = bus_addr[ADDR_W-1:2];
  assign unused_byte_lane = bus_addr[1:0];

  sysctl_decode #(.IDX_W(IDX_W), .NUM_TIMERS(NUM_TIMERS)) u_decode (
    .idx(idx), .valid(bus_valid), .write(bus_write),
    .hit(hit), .tsel(tmr_sel), .tsub(tmr_sub)
  );

  sysctl_gpio_regs u_gpio (
    .clk(clk), .rst_n(rst_n), .hit(hit), .wdata(bus_wdata),
    .gpio_out(gpio_out), .irq_en(gpio_irq_en)
  );

  sysctl_strobe u_strobe (
    .clk(clk), .rst_n(rst_n), .hit(hit), .cmd(bus_wdata[15:0]),
    .reset_req(reset_req), .shutdown_req(shutdown_req)
  );

  sysctl_rdmux #(
    .IDX_W(IDX_W), .NUM_TIMERS(NUM_TIMERS),
    .STRAP(STRAP), .CAPS(CAPS), .SYS_ID(SYS_ID)
  ) u_rdmux (
    .idx(idx), .tsel(tmr_sel), .gpio_out(gpio_out), .irq_en(gpio_irq_en),
    .tmr_rdata(tmr_rdata), .rdata(rd_mux)
  );

  assign tmr_write = bus_write;
  assign tmr_wdata = bus_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= bus_valid && !bus_write;
      if (bus_valid && !bus_write) rd_data <= rd_mux;
    end
  end
endmodule

// File: rtl/sysctl_bank_chk.sv
module sysctl_bank_chk #(
  parameter int ADDR_W     = 8,
  parameter int NUM_TIMERS = 2
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  bus_valid,
  input logic                  bus_write,
  input logic [ADDR_W-1:0]     bus_addr,
  input logic [15:0]           cmd_lo,
  input logic                  rd_valid,
  input logic [31:0]           gpio_out,
  input logic [31:0]           gpio_irq_en,
  input logic [NUM_TIMERS-1:0] tmr_sel,
  input logic                  tmr_write,
  input logic                  reset_req,
  input logic                  shutdown_req
);
  logic [ADDR_W-3:0] cidx;
  logic              wr_now;
  assign cidx   = bus_addr[ADDR_W-1:2];
  assign wr_now = bus_valid && bus_write;

  assert_reset_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |-> $past(wr_now && cidx == (ADDR_W-2)'(15)));

  assert_shutdown_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown_req |-> $past(wr_now && cidx == (ADDR_W-2)'(13) && cmd_lo == 16'h000E));

  assert_read_response_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(bus_valid && !bus_write));

  assert_timer_sel_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tmr_sel));

  assert_timer_write_target_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && tmr_write && tmr_sel != '0) |-> $countones(tmr_sel) == 1);

  assert_gpio_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_now && cidx == (ADDR_W-2)'(1)) |=> $stable(gpio_out));

  assert_irq_en_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_now && cidx == (ADDR_W-2)'(2)) |=> $stable(gpio_irq_en));
endmodule

bind sysctl_bank sysctl_bank_chk #(.ADDR_W(ADDR_W), .NUM_TIMERS(NUM_TIMERS)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_addr(bus_addr), .cmd_lo(bus_wdata[15:0]), .rd_valid(rd_valid),
  .gpio_out(gpio_out), .gpio_irq_en(gpio_irq_en), .tmr_sel(tmr_sel),
  .tmr_write(tmr_write), .reset_req(reset_req), .shutdown_req(shutdown_req)
);

// File: tb/sysctl_bank_bench.sv
module sysctl_bank_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 8;
  localparam int NT = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        rd_valid;
  logic [31:0] rd_data, gpio_out, gpio_irq_en, tmr_wdata;
  logic [NT-1:0] tmr_sel;
  logic        tmr_write, reset_req, shutdown_req;
  logic [1:0]  tmr_sub;
  logic [32*NT-1:0] tmr_rdata;

  int checks = 0, fails = 0;
  logic [31:0] m_gpio = '0, m_en = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // Timer stand-ins: timer0 returns A000_000s, timer1 B000_000s (s = sub-index)
  assign tmr_rdata = {32'hB000_0000 | {30'd0, tmr_sub}, 32'hA000_0000 | {30'd0, tmr_sub}};

  sysctl_bank u_sysctl_bank (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rd_valid(rd_valid),
    .rd_data(rd_data), .gpio_out(gpio_out), .gpio_irq_en(gpio_irq_en),
    .tmr_sel(tmr_sel), .tmr_write(tmr_write), .tmr_sub(tmr_sub),
    .tmr_wdata(tmr_wdata), .tmr_rdata(tmr_rdata), .reset_req(reset_req),
    .shutdown_req(shutdown_req)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(int i);
    case (i)
      0: return 32'h0000_0001;
      1: return m_gpio;
      2: return m_en;
      4, 5, 6: return 32'hA000_0000 | (i - 4);
      8, 9, 10: return 32'hB000_0000 | (i - 8);
      13: return 32'h0000_0001;
      14: return 32'h0000_0000;
      15: return 32'h1001_4D31;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [NT-1:0] exp_sel(int i);
    if (i >= 4 && i <= 6) return 2'b01;
    if (i >= 8 && i <= 10) return 2'b10;
    return 2'b00;
  endfunction

  // One access; byte-lane bits taken from lane to exercise R1
  task automatic access(bit wr, int i, logic [1:0] lane, logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = wr;
    bus_addr = ADDR_W'((i << 2) | lane); bus_wdata = d;
    #1;
    check("R8 sel", {30'd0, tmr_sel}, {30'd0, exp_sel(i)});
    if (exp_sel(i) != 0) begin
      check("R8 sub", {30'd0, tmr_sub}, 32'(i % 4));
      check("R8 write", {31'd0, tmr_write}, {31'd0, wr});
      check("R8 wdata", tmr_wdata, d);
    end
    @(negedge clk);
    bus_valid = 1'b0;
    check("R3 rd_valid", {31'd0, rd_valid}, {31'd0, !wr});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R2 gpio_out", gpio_out, 32'h0);
    check("R2 irq_en", gpio_irq_en, 32'h0);
    check("R2 reset_req", {31'd0, reset_req}, 32'h0);
    rst_n = 1'b1;

    // Reset-value sweep over every index, varying byte-lane bits (R1, R2, R8, R9)
    for (int i = 0; i < 64; i++) begin
      access(1'b0, i, 2'(i), 32'h0);
      check($sformatf("R2/R9 read idx %0d", i), rd_data, exp_read(i));
    end

    // Write sweep: distinct pattern per index, check side effects (R4,R5,R6,R9)
    for (int i = 0; i < 64; i++) begin
      logic [31:0] p;
      p = 32'h5A00_0000 ^ (32'(i) * 32'h0101_0101);
      access(1'b1, i, 2'(3 - (i % 4)), p);
      if (i == 1) m_gpio = p;
      if (i == 2) m_en = p;
      check($sformatf("R6 reset_req idx %0d", i), {31'd0, reset_req}, {31'd0, i == 15});
      check($sformatf("R9 shutdown idx %0d", i), {31'd0, shutdown_req}, 32'h0);
      check($sformatf("R4 gpio_out idx %0d", i), gpio_out, m_gpio);
      check($sformatf("R4 irq_en idx %0d", i), gpio_irq_en, m_en);
      @(negedge clk);
      check("R6 pulse width", {31'd0, reset_req}, 32'h0);
    end

    // Read-back sweep: read-only and reserved stay, GPIO holds writes (R4, R5, R9)
    for (int i = 0; i < 64; i++) begin
      access(1'b0, i, 2'(i + 1), 32'h0);
      check($sformatf("R5/R9 readback idx %0d", i), rd_data, exp_read(i));
    end

    // Configuration-port commands (R7)
    access(1'b1, 13, 2'd0, 32'hFFFF_000E);
    check("R7 shutdown pulse", {31'd0, shutdown_req}, 32'h1);
    @(negedge clk);
    check("R7 pulse width", {31'd0, shutdown_req}, 32'h0);
    access(1'b1, 13, 2'd2, 32'h0000_000F);
    check("R7 other cmd", {31'd0, shutdown_req}, 32'h0);
    access(1'b1, 13, 2'd1, 32'h000E_0000);
    check("R7 high half", {31'd0, shutdown_req}, 32'h0);
    access(1'b1, 13, 2'd3, 32'h0000_000E);
    check("R7 exact cmd", {31'd0, shutdown_req}, 32'h1);
    access(1'b0, 13, 2'd0, 32'h0);
    check("R7 cfg reads ready", rd_data, 32'h0000_0001);
    access(1'b1, 15, 2'd0, 32'h0);
    access(1'b0, 15, 2'd0, 32'h0);
    check("R6 id unchanged", rd_data, 32'h1001_4D31);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule